// File: doc/BRIEF.md
# Indexed Effective-Address Generator with Page-Cross Fix-Up

This block forms the operand address for absolute indexed addressing. A start pulse captures a base address and an index. The index is added to the low part of the base with a narrow adder only. On the next cycle the block issues a bus read at the sum's low part, joined to the base's unchanged high part.

If that narrow add produced no carry, the first read is the real operand read and the operation ends there. If it carried, the first read is a dummy read that lands on the lower, uncorrected page. The high part is then incremented, and the corrected read follows one cycle later. Each cycle of an operation drives the read strobe. A page-cross flag comes out together with the completion flag, so that a sequencer can account for the extra cycle.

The controller has three states:
- `ST_IDLE`: no read is issued. On start it goes to `ST_PROBE`.
- `ST_PROBE`: the first read, at {base high, sum low}. Without a carry it completes. It then goes to `ST_PROBE` if start is high, else to `ST_IDLE`. With a carry it goes to `ST_FIXUP`, and start is ignored.
- `ST_FIXUP`: the corrected read, at {base high + 1, sum low}. It completes here and then goes to `ST_PROBE` on start, else to `ST_IDLE`.

Top module: `idx_addr_gen`

## Requirements
- R1: Out of reset, `bus_rd_o`, `done_o` and `page_cross_o` are all 0.
- R2: The cycle after a start is accepted, `bus_rd_o` is 1. In that cycle `bus_addr_o` equals {base[15:8], (base[7:0] + index) mod 256}.
- R3: If base[7:0] + index < 256, that first read cycle has `done_o` = 1 and `page_cross_o` = 0. With no new start, `bus_rd_o` is 0 in the following cycle.
- R4: If base[7:0] + index >= 256, the first read cycle has `done_o` = 0. The next cycle has `bus_rd_o` = 1, `done_o` = 1, `page_cross_o` = 1, and `bus_addr_o` equals {base[15:8] + 1, sum low}, keeping the same low byte.
- R5: In the corrected read, the high byte wraps from 0xFF to 0x00.
- R6: `page_cross_o` is 1 only while `done_o` is 1. Completion takes 1 cycle without a page cross and 2 cycles with one.
- R7: A start raised in the first cycle of a crossing operation is ignored. The operation completes with its own address, and no read follows it.
- R8: A start raised in a cycle with `done_o` = 1 is accepted. The new operation's first read appears in the very next cycle.
- R9: While `done_o` is 1, `eff_addr_o` equals (base + index) mod 65536 and equals `bus_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an address computation |
| base_i | input | 16 | Base address, sampled on an accepted start |
| index_i | input | 8 | Index value, sampled on an accepted start |
| bus_addr_o | output | 16 | Address of the read issued this cycle |
| bus_rd_o | output | 1 | Read strobe, high in every cycle of an operation |
| done_o | output | 1 | The read this cycle is the real operand read |
| page_cross_o | output | 1 | The completing operation needed the fix-up cycle |
| eff_addr_o | output | 16 | Final effective address, valid with done_o |

## Verification
The bench builds the block with its default widths: a 16-bit address and an 8-bit page offset. With these widths, page 0xFF and the low-byte edge at 0xFF can be reached with single directed vectors. That covers the wrap of the high byte to 0x00 and the carry boundary between index sums of 255 and 256. Back-to-back starts and starts raised during a dummy read are driven at exact cycles, to show which starts the controller accepts.

// File: rtl/idx_addr_pkg.sv
package idx_addr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_FIXUP = 2'd2
    } idx_state_e;
endpackage

// File: rtl/idx_lo_add.sv
// Narrow adder: offset part of the base plus the index, with carry out.
module idx_lo_add #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] base_lo_i,
    input  logic [PAGE_W-1:0] index_i,
    output logic [PAGE_W-1:0] sum_lo_o,
    output logic              carry_o
);
    logic [PAGE_W:0] wide_sum;

    assign wide_sum = {1'b0, base_lo_i} + {1'b0, index_i};
    assign sum_lo_o = wide_sum[PAGE_W-1:0];
    assign carry_o  = wide_sum[PAGE_W];
endmodule

// File: rtl/idx_hi_inc.sv
// Page incrementer used only in the fix-up cycle; wraps at the top page.
module idx_hi_inc #(
    parameter int HI_W = 8
) (
    input  logic [HI_W-1:0] hi_i,
    output logic [HI_W-1:0] hi_next_o
);
    assign hi_next_o = hi_i + HI_W'(1);
endmodule

// File: rtl/idx_fsm.sv
module idx_fsm
    import idx_addr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic carry_q_i,
    output logic accept_o,
    output logic fix_sel_o,
    output logic bus_rd_o,
    output logic done_o,
    output logic page_cross_o
);
    idx_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_PROBE;
            ST_PROBE: begin
                if (carry_q_i)    state_d = ST_FIXUP;
                else if (start_i) state_d = ST_PROBE;
                else              state_d = ST_IDLE;
            end
            ST_FIXUP: state_d = start_i ? ST_PROBE : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        accept_o     = 1'b0;
        fix_sel_o    = 1'b0;
        bus_rd_o     = 1'b0;
        done_o       = 1'b0;
        page_cross_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept_o = start_i;
            ST_PROBE: begin
                bus_rd_o = 1'b1;
                done_o   = !carry_q_i;
                accept_o = start_i && !carry_q_i;
            end
            ST_FIXUP: begin
                bus_rd_o     = 1'b1;
                fix_sel_o    = 1'b1;
                done_o       = 1'b1;
                page_cross_o = 1'b1;
                accept_o     = start_i;
            end
            default: ;
        endcase
    end

    // R4: the fix-up state is only ever entered from the probe state
    a_r4_fix_after_probe: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIXUP) |-> ($past(state_q) == ST_PROBE));

    // R2: a start seen while idle always leads to the probe read
    a_r2_probe_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && state_q == ST_IDLE) |=> (state_q == ST_PROBE));

    // R7: a start during a crossing probe does not skip the fix-up
    a_r7_no_skip_fix: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROBE && carry_q_i) |=> (state_q == ST_FIXUP));
endmodule

// File: rtl/idx_addr_gen.sv
module idx_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [PAGE_W-1:0] index_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_rd_o,
    output logic              done_o,
    output logic              page_cross_o,
    output logic [ADDR_W-1:0] eff_addr_o
);
    localparam int HI_W = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] sum_lo_d, lo_q;
    logic              carry_d, cy_q;
    logic [HI_W-1:0]   hi_q, hi_inc;
    logic              accept, fix_sel;

    idx_lo_add #(.PAGE_W(PAGE_W)) u_lo_add (
        .base_lo_i (base_i[PAGE_W-1:0]),
        .index_i   (index_i),
        .sum_lo_o  (sum_lo_d),
        .carry_o   (carry_d)
    );

    idx_hi_inc #(.HI_W(HI_W)) u_hi_inc (
        .hi_i      (hi_q),
        .hi_next_o (hi_inc)
    );

    idx_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .carry_q_i    (cy_q),
        .accept_o     (accept),
        .fix_sel_o    (fix_sel),
        .bus_rd_o     (bus_rd_o),
        .done_o       (done_o),
        .page_cross_o (page_cross_o)
    );

    // Operand capture on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
            cy_q <= 1'b0;
        end else if (accept) begin
            hi_q <= base_i[ADDR_W-1:PAGE_W];
            lo_q <= sum_lo_d;
            cy_q <= carry_d;
        end
    end

    assign bus_addr_o = fix_sel ? {hi_inc, lo_q} : {hi_q, lo_q};
    assign eff_addr_o = cy_q    ? {hi_inc, lo_q} : {hi_q, lo_q};

    // R4: corrected read keeps the dummy read's low byte
    a_r4_same_low: assert property (@(posedge clk) disable iff (!rst_n)
        fix_sel |-> (bus_addr_o[PAGE_W-1:0] == $past(bus_addr_o[PAGE_W-1:0])));

    // R5: corrected read is one page above the dummy read, wrapping at the top
    a_r5_page_up: assert property (@(posedge clk) disable iff (!rst_n)
        fix_sel |-> (bus_addr_o[ADDR_W-1:PAGE_W] ==
                     HI_W'($past(bus_addr_o[ADDR_W-1:PAGE_W]) + HI_W'(1))));

    // R6: page-cross is only reported together with completion
    a_r6_cross_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        page_cross_o |-> done_o);

    // R9: the completing read is at the effective address
    a_r9_eff_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (eff_addr_o == bus_addr_o && bus_rd_o));
endmodule

// File: tb/tb_idx_addr_gen.sv
module tb_idx_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] base_i = '0;
    logic [7:0]  index_i = '0;
    logic [15:0] bus_addr_o, eff_addr_o;
    logic        bus_rd_o, done_o, page_cross_o;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    idx_addr_gen dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .index_i(index_i), .bus_addr_o(bus_addr_o), .bus_rd_o(bus_rd_o),
        .done_o(done_o), .page_cross_o(page_cross_o), .eff_addr_o(eff_addr_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Checks the read cycles of one operation; called at the negedge after the accepting edge.
    task automatic check_op(input logic [15:0] b, input logic [7:0] ix);
        logic [8:0]  s = {1'b0, b[7:0]} + {1'b0, ix};
        logic [15:0] eff = b + {8'h00, ix};
        check("R2 rd first", {31'd0, bus_rd_o}, 1);
        check("R2 addr first", {16'd0, bus_addr_o}, {16'd0, b[15:8], s[7:0]});
        if (!s[8]) begin
            check("R3 done first", {31'd0, done_o}, 1);
            check("R3 cross first", {31'd0, page_cross_o}, 0);
            check("R9 eff", {16'd0, eff_addr_o}, {16'd0, eff});
        end else begin
            check("R4 no done on dummy", {31'd0, done_o}, 0);
            check("R6 no cross on dummy", {31'd0, page_cross_o}, 0);
            @(negedge clk);
            check("R4 rd fix", {31'd0, bus_rd_o}, 1);
            check("R4 done fix", {31'd0, done_o}, 1);
            check("R4 cross fix", {31'd0, page_cross_o}, 1);
            check("R5 addr fix", {16'd0, bus_addr_o}, {16'd0, b[15:8] + 8'd1, s[7:0]});
            check("R9 eff", {16'd0, eff_addr_o}, {16'd0, eff});
        end
    endtask

    task automatic run_op(input logic [15:0] b, input logic [7:0] ix);
        @(negedge clk);
        start_i = 1'b1; base_i = b; index_i = ix;
        @(negedge clk);
        start_i = 1'b0;
        check_op(b, ix);
        @(negedge clk);
        check("R3 idle after op", {31'd0, bus_rd_o}, 0);
    endtask

    task automatic t_reset();
        check("R1 rd", {31'd0, bus_rd_o}, 0);
        check("R1 done", {31'd0, done_o}, 0);
        check("R1 cross", {31'd0, page_cross_o}, 0);
    endtask

    task automatic t_nocross();  run_op(16'h1234, 8'h10); run_op(16'h40F0, 8'h0F); run_op(16'h20FF, 8'h00); endtask
    task automatic t_cross();    run_op(16'h1280, 8'h80); run_op(16'h30FF, 8'h01); run_op(16'h55C3, 8'hFF); endtask
    task automatic t_wrap();     run_op(16'hFFF0, 8'h20); endtask

    // R6: latency 1 without a cross, 2 with one
    task automatic t_latency(input logic [15:0] b, input logic [7:0] ix, input int exp_lat);
        int lat = 0;
        @(negedge clk);
        start_i = 1'b1; base_i = b; index_i = ix;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 5) begin @(negedge clk); lat++; end
        check("R6 latency", lat, exp_lat);
        @(negedge clk);
    endtask

    // R7: start during a dummy read is ignored
    task automatic t_ignore();
        @(negedge clk);
        start_i = 1'b1; base_i = 16'h0AF0; index_i = 8'h20;
        @(negedge clk);
        base_i = 16'h7700; index_i = 8'h01;
        check("R7 dummy done", {31'd0, done_o}, 0);
        @(negedge clk);
        start_i = 1'b0;
        check("R7 fix addr", {16'd0, bus_addr_o}, 32'h0B10);
        check("R7 fix cross", {31'd0, page_cross_o}, 1);
        @(negedge clk);
        check("R7 no extra read", {31'd0, bus_rd_o}, 0);
    endtask

    // R8: start in a done cycle is accepted back to back
    task automatic t_back2back();
        @(negedge clk);
        start_i = 1'b1; base_i = 16'h1000; index_i = 8'h05;
        @(negedge clk);
        base_i = 16'h22F8; index_i = 8'h10;
        check("R8 first done", {31'd0, done_o}, 1);
        check("R8 first addr", {16'd0, bus_addr_o}, 32'h1005);
        @(negedge clk);
        start_i = 1'b0;
        check_op(16'h22F8, 8'h10);
        @(negedge clk);
        check("R8 idle", {31'd0, bus_rd_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nocross();
        t_cross();
        t_wrap();
        t_latency(16'h0140, 8'h40, 1);
        t_latency(16'h01C0, 8'h40, 2);
        t_ignore();
        t_back2back();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule